// File: doc/BRIEF.md
# Clock Power-Down Sequencer

This block sits between a clock synthesizer's running outputs and its pins. When the asynchronous active-low power-down input is asserted, the sequencer first confirms the request. The confirmation needs two consecutive rising edges of the reference pair's complement clock. It then parks every output cleanly. Single-ended clocks are held low. Each differential pair is held with its true side high. Only when every lane is parked does it drop the oscillator/PLL enable.

When the request is released, the enable returns at once. Any pair that was floated is driven again straight away, with its true side high. A parameterised wait then stands in for the analog stabilisation time. After that wait, every lane is released at a point in its own input waveform where releasing cannot create a short pulse.

Differential pairs have a per-pair mode input, which is 0 after a system reset. Mode 0 keeps the true side driven high and floats the complement. Mode 1 floats both sides. Current-mode levels are modelled only as a data value plus an output-enable for each side.

Top module: `clkpd_sequencer`

## Requirements
- R1: No output is stopped and `osc_en` stays high until the synchronised `pd_n` has been seen low on two consecutive complement rising edges of the reference pair. A complement rising edge is a 1-to-0 step of `dp_clk_i[REF_PAIR]`.
- R2: While parking, each single-ended output `se_clk_o[k]` follows its input until the input's next 1-to-0 step. It then stays 0 until restart.
- R3: While parking, each true output `dp_t_o[j]` follows its input until the input's next 0-to-1 step, which is the complement's high-to-low step. It then stays 1 until restart. `dp_c_o` is always the inverse of `dp_t_o`.
- R4: Output enables are active high. While parked and the oscillator is off, a pair with `dp_float_mode[j]`=0 has `dp_t_oe[j]`=1 and `dp_c_oe[j]`=0. A pair with `dp_float_mode[j]`=1 has both enables 0.
- R5: `osc_en` falls only when every lane is parked (all `se_clk_o` 0, all `dp_t_o` 1, all `dp_c_oe` 0). It stays low for as long as `pd_n` remains low.
- R6: After `pd_n` is released, `osc_en` returns within a few cycles. `clocks_stable` rises no earlier than STABLE_CYC cycles, and no later than STABLE_CYC+12 cycles, after the release.
- R7: In the first cycle that `osc_en` is high again, every pair has both enables at 1 and its true output at 1.
- R8: On restart a single-ended lane is freed only while its input is 0, and a pair only while its true input is 1. No output edge therefore occurs without a matching input edge. While `clocks_stable` is 1, every output equals its input and all enables are 1.
- R9: If `pd_n` returns high before the second qualifying edge, the block goes back to normal running with no clock stopped and `osc_en` held high.
- R10: After reset, `osc_en` and `clocks_stable` are 1, outputs follow inputs and all enables are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Asynchronous active-low power-down request |
| se_clk_i | input | N_SE | Running single-ended clocks |
| dp_clk_i | input | N_DIFF | True side of each running differential pair |
| dp_float_mode | input | N_DIFF | Per-pair park mode: 0 true driven high, 1 both floating |
| se_clk_o | output | N_SE | Gated single-ended clocks |
| dp_t_o | output | N_DIFF | Gated true outputs |
| dp_c_o | output | N_DIFF | Gated complement outputs |
| dp_t_oe | output | N_DIFF | True-side output enable |
| dp_c_oe | output | N_DIFF | Complement-side output enable |
| osc_en | output | 1 | Oscillator/PLL enable |
| clocks_stable | output | 1 | Outputs running normally |

## Verification
Two functions can land in the same cycle: the stabilisation restart and a fresh power-down request. The bench raises `pd_n` and then lowers it again a few cycles after `osc_en` returns, while the wait count is still running. It judges that case by requiring `clocks_stable` to appear once, followed by a second complete qualify-and-park sequence with the correct per-pair modes. Short low pulses that cover at most one qualifying edge sit beside full parks in the stimulus table. They show that confirmation and abort are decided on the same edge stream.

// File: rtl/clkpd_pkg.sv
package clkpd_pkg;
   typedef enum logic [2:0] {
      ST_RUN     = 3'd0,
      ST_QUAL    = 3'd1,
      ST_PARK    = 3'd2,
      ST_OFF     = 3'd3,
      ST_WAKE    = 3'd4,
      ST_RESTART = 3'd5
   } pd_state_e;
endpackage

// File: rtl/clkpd_sync.sv
module clkpd_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_n,
   output logic sync_n
);
   logic [STAGES-1:0] sh_q;

   generate
      if (STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh_q <= '1;
            else        sh_q <= async_n;
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sh_q <= '1;
            else        sh_q <= {sh_q[STAGES-2:0], async_n};
      end
   endgenerate

   assign sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/clkpd_fsm.sv
module clkpd_fsm
   import clkpd_pkg::*;
#(
   parameter int STABLE_CYC = 25772
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pd_req,
   input  logic      ref_true,
   input  logic      all_parked,
   input  logic      all_released,
   output pd_state_e state
);
   localparam int CW = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC + 1);
   localparam logic [CW-1:0] LAST = CW'(STABLE_CYC - 1);

   pd_state_e nxt;
   logic          ref_q;
   logic [CW-1:0] wait_q;
   logic          comp_rise;

   // complement rises exactly when the true side falls
   assign comp_rise = ref_q & ~ref_true;

   always_comb begin
      nxt = state;
      unique case (state)
         ST_RUN:     if (pd_req && comp_rise) nxt = ST_QUAL;
         ST_QUAL:    if (!pd_req) nxt = ST_RUN;
                     else if (comp_rise) nxt = ST_PARK;
         ST_PARK:    if (all_parked) nxt = ST_OFF;
         ST_OFF:     if (!pd_req) nxt = ST_WAKE;
         ST_WAKE:    if (wait_q == LAST) nxt = ST_RESTART;
         ST_RESTART: if (all_released) nxt = ST_RUN;
         default:    nxt = ST_RUN;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_RUN;
         ref_q  <= 1'b0;
         wait_q <= '0;
      end else begin
         state <= nxt;
         ref_q <= ref_true;
         if (state == ST_WAKE) wait_q <= wait_q + 1'b1;
         else                  wait_q <= '0;
      end
   end
endmodule

// File: rtl/clkpd_se_lane.sv
module clkpd_se_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic park,
   input  logic rel_ph,
   input  logic clk_in,
   output logic clk_out,
   output logic held
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         held   <= 1'b0;
      end else begin
         prev_q <= clk_in;
         if (!held && park && prev_q && !clk_in)
            held <= 1'b1;                       // R2: catch the falling step
         else if (held && rel_ph && !clk_in)
            held <= 1'b0;                       // R8: free only in the low phase
      end
   end

   assign clk_out = clk_in & ~held;
endmodule

// File: rtl/clkpd_diff_lane.sv
module clkpd_diff_lane (
   input  logic clk,
   input  logic rst_n,
   input  logic park,
   input  logic rel_ph,
   input  logic float_ph,
   input  logic float_mode,
   input  logic t_in,
   output logic t_out,
   output logic c_out,
   output logic t_oe,
   output logic c_oe,
   output logic held
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         held   <= 1'b0;
      end else begin
         prev_q <= t_in;
         if (!held && park && !prev_q && t_in)
            held <= 1'b1;                       // R3: complement just fell
         else if (held && rel_ph && t_in)
            held <= 1'b0;                       // R8: free only in the high phase
      end
   end

   assign t_out = t_in | held;
   assign c_out = ~t_out;
   // R4: complement floats when parked; true floats only in mode 1
   assign c_oe  = ~(held & float_ph);
   assign t_oe  = ~(held & float_ph & float_mode);
endmodule

// File: rtl/clkpd_sequencer.sv
module clkpd_sequencer
   import clkpd_pkg::*;
#(
   parameter int N_SE        = 16,
   parameter int N_DIFF      = 5,
   parameter int REF_PAIR    = 0,
   parameter int SYNC_STAGES = 2,
   parameter int STABLE_CYC  = 25772
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pd_n,
   input  logic [N_SE-1:0]   se_clk_i,
   input  logic [N_DIFF-1:0] dp_clk_i,
   input  logic [N_DIFF-1:0] dp_float_mode,
   output logic [N_SE-1:0]   se_clk_o,
   output logic [N_DIFF-1:0] dp_t_o,
   output logic [N_DIFF-1:0] dp_c_o,
   output logic [N_DIFF-1:0] dp_t_oe,
   output logic [N_DIFF-1:0] dp_c_oe,
   output logic              osc_en,
   output logic              clocks_stable
);
   generate
      if (N_SE < 1)                             begin : g_bad_se   $error("N_SE must be at least 1");               end
      if (N_DIFF < 1)                           begin : g_bad_diff $error("N_DIFF must be at least 1");             end
      if (REF_PAIR < 0 || REF_PAIR >= N_DIFF)   begin : g_bad_ref  $error("REF_PAIR must index a pair");            end
      if (SYNC_STAGES < 1)                      begin : g_bad_sync $error("SYNC_STAGES must be at least 1");        end
      if (STABLE_CYC < 1)                       begin : g_bad_wait $error("STABLE_CYC must be at least 1");         end
   endgenerate

   pd_state_e         state;
   logic              pd_sync_n;
   logic              park, rel_ph, float_ph;
   logic [N_SE-1:0]   se_held;
   logic [N_DIFF-1:0] dp_held;
   logic              all_parked, all_released;

   clkpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_n(pd_n), .sync_n(pd_sync_n)
   );

   clkpd_fsm #(.STABLE_CYC(STABLE_CYC)) u_fsm (
      .clk(clk), .rst_n(rst_n), .pd_req(~pd_sync_n),
      .ref_true(dp_clk_i[REF_PAIR]),
      .all_parked(all_parked), .all_released(all_released),
      .state(state)
   );

   assign park     = (state == ST_PARK) || (state == ST_OFF) || (state == ST_WAKE);
   assign float_ph = (state == ST_PARK) || (state == ST_OFF);
   assign rel_ph   = (state == ST_RESTART);

   genvar k;
   generate
      for (k = 0; k < N_SE; k++) begin : g_se
         clkpd_se_lane u_lane (
            .clk(clk), .rst_n(rst_n), .park(park), .rel_ph(rel_ph),
            .clk_in(se_clk_i[k]), .clk_out(se_clk_o[k]), .held(se_held[k])
         );
      end
      for (k = 0; k < N_DIFF; k++) begin : g_dp
         clkpd_diff_lane u_lane (
            .clk(clk), .rst_n(rst_n), .park(park), .rel_ph(rel_ph),
            .float_ph(float_ph), .float_mode(dp_float_mode[k]),
            .t_in(dp_clk_i[k]), .t_out(dp_t_o[k]), .c_out(dp_c_o[k]),
            .t_oe(dp_t_oe[k]), .c_oe(dp_c_oe[k]), .held(dp_held[k])
         );
      end
   endgenerate

   assign all_parked    = (&se_held) & (&dp_held);
   assign all_released  = ~(|se_held) & ~(|dp_held);
   assign osc_en        = (state != ST_OFF);
   assign clocks_stable = (state == ST_RUN) || (state == ST_QUAL);
endmodule

// File: rtl/clkpd_sequencer_chk.sv
module clkpd_sequencer_chk #(
   parameter int N_SE   = 16,
   parameter int N_DIFF = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SE-1:0]   se_clk_i,
   input logic [N_DIFF-1:0] dp_clk_i,
   input logic [N_DIFF-1:0] dp_float_mode,
   input logic [N_SE-1:0]   se_clk_o,
   input logic [N_DIFF-1:0] dp_t_o,
   input logic [N_DIFF-1:0] dp_c_o,
   input logic [N_DIFF-1:0] dp_t_oe,
   input logic [N_DIFF-1:0] dp_c_oe,
   input logic              osc_en,
   input logic              clocks_stable
);
   a_r5_off_parked: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (se_clk_o == '0 && dp_t_o == '1 && dp_c_oe == '0));

   a_r4_park_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_en |-> (dp_t_oe == ~dp_float_mode));

   a_r7_redrive: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(osc_en) |-> (dp_t_oe == '1 && dp_c_oe == '1 && dp_t_o == '1));

   a_r2_se_edges: assert property (@(posedge clk) disable iff (!rst_n)
      ((se_clk_o & ~$past(se_clk_o) & ~(se_clk_i & ~$past(se_clk_i))) == '0) &&
      ((~se_clk_o & $past(se_clk_o) & ~(~se_clk_i & $past(se_clk_i))) == '0));

   a_r3_dp_edges: assert property (@(posedge clk) disable iff (!rst_n)
      ((dp_t_o & ~$past(dp_t_o) & ~(dp_clk_i & ~$past(dp_clk_i))) == '0) &&
      ((~dp_t_o & $past(dp_t_o) & ~(~dp_clk_i & $past(dp_clk_i))) == '0));

   a_r3_comp_inverse: assert property (@(posedge clk) disable iff (!rst_n)
      dp_c_o == ~dp_t_o);

   a_r8_stable_pass: assert property (@(posedge clk) disable iff (!rst_n)
      clocks_stable |-> (se_clk_o == se_clk_i && dp_t_o == dp_clk_i &&
                         dp_t_oe == '1 && dp_c_oe == '1));
endmodule

bind clkpd_sequencer clkpd_sequencer_chk #(.N_SE(N_SE), .N_DIFF(N_DIFF)) u_chk (
   .clk(clk), .rst_n(rst_n), .se_clk_i(se_clk_i), .dp_clk_i(dp_clk_i),
   .dp_float_mode(dp_float_mode), .se_clk_o(se_clk_o), .dp_t_o(dp_t_o),
   .dp_c_o(dp_c_o), .dp_t_oe(dp_t_oe), .dp_c_oe(dp_c_oe),
   .osc_en(osc_en), .clocks_stable(clocks_stable)
);

// File: tb/clkpd_sequencer_test.sv
module clkpd_sequencer_test;
   localparam int NS = 4;
   localparam int ND = 3;
   localparam int WT = 40;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_n = 1'b1;
   logic [NS-1:0] se_clk_i = '0;
   logic [ND-1:0] dp_clk_i = '0;
   logic [ND-1:0] dp_float_mode = '0;
   logic [NS-1:0] se_clk_o;
   logic [ND-1:0] dp_t_o, dp_c_o, dp_t_oe, dp_c_oe;
   logic osc_en, clocks_stable;

   int tests = 0;
   int failed = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   clkpd_sequencer #(.N_SE(NS), .N_DIFF(ND), .REF_PAIR(0), .SYNC_STAGES(2), .STABLE_CYC(WT)) uut (
      .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .se_clk_i(se_clk_i), .dp_clk_i(dp_clk_i),
      .dp_float_mode(dp_float_mode), .se_clk_o(se_clk_o), .dp_t_o(dp_t_o), .dp_c_o(dp_c_o),
      .dp_t_oe(dp_t_oe), .dp_c_oe(dp_c_oe), .osc_en(osc_en), .clocks_stable(clocks_stable)
   );

   // free-running source clocks, changed on falling sequencer edges
   always @(negedge clk) begin
      cyc = cyc + 1;
      for (int k = 0; k < NS; k++) se_clk_i[k] = ((cyc + k) / 3) % 2 == 1;
      for (int j = 0; j < ND; j++) dp_clk_i[j] = ((cyc + j) / 2) % 2 == 1;
   end

   // edge monitor: R8 glitch rule and R1 qualification rule
   logic [NS-1:0] p_si, p_so;
   logic [ND-1:0] p_di, p_do;
   logic p_pd = 1'b1;
   bit   mon_on = 1'b0;
   int   glitch_err = 0, r1_err = 0, r1_edges = 0;
   bit   r1_arm = 1'b0;

   always @(negedge clk) begin
      #2;
      if (rst_n && mon_on) begin
         if ((se_clk_o & ~p_so & ~(se_clk_i & ~p_si)) != 0 ||
             (~se_clk_o & p_so & ~(~se_clk_i & p_si)) != 0 ||
             (dp_t_o & ~p_do & ~(dp_clk_i & ~p_di)) != 0 ||
             (~dp_t_o & p_do & ~(~dp_clk_i & p_di)) != 0 ||
             (se_clk_o & ~se_clk_i) != 0 || (~dp_t_o & dp_clk_i) != 0)
            glitch_err++;
         if (pd_n) begin
            r1_arm = 1'b0; r1_edges = 0;
         end else begin
            if (p_pd && clocks_stable) r1_arm = 1'b1;
            if (p_di[0] && !dp_clk_i[0]) r1_edges++;
            if (r1_arm && r1_edges < 2 &&
                (!osc_en || se_clk_o != se_clk_i || dp_t_o != dp_clk_i)) r1_err++;
         end
      end
      p_si = se_clk_i; p_so = se_clk_o; p_di = dp_clk_i; p_do = dp_t_o; p_pd = pd_n;
      if (rst_n) mon_on = 1'b1;
   end

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         failed++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input int n);
      repeat (n) begin @(negedge clk); #1; end
   endtask

   // lower pd_n and wait for the oscillator to stop, then check parked state
   task automatic do_park(input logic [ND-1:0] dm);
      int n;
      dp_float_mode = dm;
      pd_n = 1'b0;
      n = 0;
      while (osc_en && n < 80) begin step(1); n++; end
      chk(!osc_en, "R5", "oscillator stops after parking", {31'd0, osc_en}, 32'd0);
      chk(se_clk_o == '0, "R2", "single-ended parked low", 32'(se_clk_o), 32'd0);
      chk(dp_t_o == '1 && dp_c_o == '0, "R3", "true parked high",
          32'(dp_t_o), 32'((1 << ND) - 1));
      chk(dp_t_oe == ~dm && dp_c_oe == '0, "R4", "enables follow park mode",
          {16'(dp_t_oe), 16'(dp_c_oe)}, {16'(~dm), 16'd0});
      chk(!clocks_stable, "R5", "not stable while parked", {31'd0, clocks_stable}, 32'd0);
   endtask

   task automatic do_wake();
      int n, m;
      pd_n = 1'b1;
      n = 0;
      while (!osc_en && n < 10) begin step(1); n++; end
      chk(osc_en && n <= 5, "R6", "oscillator re-enabled promptly", 32'(n), 32'd3);
      chk(dp_t_oe == '1 && dp_c_oe == '1 && dp_t_o == '1, "R7", "pairs redriven high",
          {8'(dp_t_oe), 8'(dp_c_oe), 16'(dp_t_o)}, {8'((1 << ND) - 1), 8'((1 << ND) - 1), 16'((1 << ND) - 1)});
      m = n;
      while (!clocks_stable && m < WT + 40) begin step(1); m++; end
      chk(clocks_stable && m >= WT && m <= WT + 12, "R6", "stabilisation delay",
          32'(m), 32'(WT));
      step(1);
      chk(se_clk_o == se_clk_i && dp_t_o == dp_clk_i && dp_c_o == ~dp_clk_i &&
          dp_t_oe == '1 && dp_c_oe == '1, "R8", "outputs track inputs after restart",
          {16'(se_clk_o), 16'(dp_t_o)}, {16'(se_clk_i), 16'(dp_clk_i)});
   endtask

   typedef struct packed {
      logic [ND-1:0] dm;
      logic [15:0]   len;
      logic          park;
   } vec_t;

   localparam vec_t VEC [0:6] = '{
      '{3'b000, 16'd20, 1'b1},
      '{3'b111, 16'd30, 1'b1},
      '{3'b010, 16'd3,  1'b0},
      '{3'b101, 16'd15, 1'b1},
      '{3'b000, 16'd2,  1'b0},
      '{3'b011, 16'd25, 1'b1},
      '{3'b100, 16'd3,  1'b0}
   };

   initial begin
      repeat (100000) @(posedge clk);
      failed++; tests++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end

   initial begin
      step(3);
      rst_n = 1'b1;
      step(2);
      // R10: reset state
      chk(osc_en && clocks_stable, "R10", "enable and stable after reset",
          {30'd0, osc_en, clocks_stable}, 32'd3);
      chk(se_clk_o == se_clk_i && dp_t_o == dp_clk_i && dp_t_oe == '1 && dp_c_oe == '1,
          "R10", "outputs pass after reset", {16'(se_clk_o), 16'(dp_t_o)},
          {16'(se_clk_i), 16'(dp_clk_i)});

      for (int v = 0; v < 7; v++) begin
         step(v + 3);
         if (VEC[v].park) begin
            bit low_ok;
            do_park(VEC[v].dm);
            low_ok = 1'b1;
            for (int c = 0; c < int'(VEC[v].len); c++) begin
               step(1);
               if (osc_en) low_ok = 1'b0;
            end
            chk(low_ok, "R5", "oscillator stays off while request held", 32'(low_ok), 32'd1);
            do_wake();
         end else begin
            bit run_ok;
            run_ok = 1'b1;
            dp_float_mode = VEC[v].dm;
            pd_n = 1'b0;
            for (int c = 0; c < int'(VEC[v].len); c++) begin
               step(1);
               if (!osc_en || !clocks_stable || se_clk_o != se_clk_i || dp_t_o != dp_clk_i) run_ok = 1'b0;
            end
            pd_n = 1'b1;
            for (int c = 0; c < 12; c++) begin
               step(1);
               if (!osc_en || !clocks_stable || se_clk_o != se_clk_i || dp_t_o != dp_clk_i) run_ok = 1'b0;
            end
            chk(run_ok, "R9", "short request aborted without stopping", 32'(run_ok), 32'd1);
         end
      end

      // new request arriving during the stabilisation wait
      begin
         int n;
         bit saw_stable;
         do_park(3'b110);
         pd_n = 1'b1;
         n = 0;
         while (!osc_en && n < 10) begin step(1); n++; end
         step(3);
         pd_n = 1'b0;
         saw_stable = 1'b0;
         n = 0;
         while (osc_en && n < WT + 100) begin
            step(1); n++;
            if (clocks_stable) saw_stable = 1'b1;
         end
         chk(saw_stable, "R6", "restart completes before second park", 32'(saw_stable), 32'd1);
         chk(!osc_en && se_clk_o == '0 && dp_t_o == '1, "R5", "second park reached",
             {16'(se_clk_o), 16'(dp_t_o)}, {16'd0, 16'((1 << ND) - 1)});
         chk(dp_t_oe == 3'b001 && dp_c_oe == '0, "R4", "second park modes",
             32'(dp_t_oe), 32'd1);
         do_wake();
      end

      step(10);
      chk(glitch_err == 0, "R8", "no output edge without input edge", 32'(glitch_err), 32'd0);
      chk(r1_err == 0, "R1", "nothing stops before two qualifying edges", 32'(r1_err), 32'd0);

      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
   end
endmodule